// File: doc/BRIEF.md
# Clock Page-Replacement Victim Selector

This block chooses which physical frame to evict when a new page must be brought into memory. It keeps one use bit and one dirty bit for every frame. Access reports from the translation path set these bits, and a reload report clears them once the frame has been refilled. When a victim request arrives, a circular hand pointer walks the frames one per clock cycle. It clears the use bit of each recently used frame it passes and stops at the first frame that qualifies.

The walk prefers frames that can be dropped without a write-back. During the first full lap of the hand, only frames that are both unused and clean qualify. If that lap finds nothing, any unused frame qualifies, and the selector reports whether the chosen frame is dirty. The caller then issues the write-back, updates its page tables and reports the reload. Those steps are not part of this block.

Top module: `clock_victim_sel`

## Requirements
- R1: After reset, `done` and `busy` are 0, every use and dirty bit is 0, the hand is at frame 0, and `victim_idx`/`victim_dirty` read 0.
- R2: An access report (`acc_valid`) sets the use bit of frame `acc_idx`. When `acc_write` is also 1, it sets that frame's dirty bit as well.
- R3: A request accepted in idle starts a sweep at the hand. Each following clock edge examines one frame. A frame with its use bit set has the bit cleared, and the hand moves to the next frame. `done` rises on the edge that examines the chosen frame, so the latency in edges equals the number of frames examined.
- R4: During the first lap (the first NFRAMES examinations), only a frame with use=0 and dirty=0 is accepted. Unused dirty frames are passed over and left unchanged.
- R5: If the first lap finds no candidate, any frame with use=0 is accepted from then on, and `victim_dirty` equals that frame's dirty bit.
- R6: If every frame is used and dirty when the request arrives, the victim is the frame where the sweep started, reported dirty after NFRAMES+1 examinations.
- R7: After a victim is chosen, the hand points to the next frame, wrapping from NFRAMES-1 to 0.
- R8: A reload report (`fill_valid`) clears both the use and dirty bits of frame `fill_idx`.
- R9: An access report in the same cycle as a clear of the same frame wins. A clear here is either a sweep clear or a reload. The use bit ends at 1, and with `acc_write` the dirty bit ends at 1.
- R10: `done` is a one-cycle pulse. `busy` is 1 from the edge after a request until `done` rises. A request made while `busy` is 1 is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_valid | input | 1 | Access report strobe |
| acc_idx | input | IDX_W | Frame that was accessed |
| acc_write | input | 1 | Access was a write |
| fill_valid | input | 1 | Reload report strobe |
| fill_idx | input | IDX_W | Frame that was reloaded |
| req | input | 1 | Victim request (sampled while idle) |
| busy | output | 1 | Sweep in progress |
| done | output | 1 | One-cycle pulse: victim is valid |
| victim_idx | output | IDX_W | Chosen frame |
| victim_dirty | output | 1 | Chosen frame needs a write-back |

## Verification
The assertions check several properties on every cycle. The hand advances by exactly one frame per examining cycle. `done` never lasts two cycles and never coincides with `busy`. A first-lap victim is never dirty. Access and reload reports leave the expected bit values one cycle later, with access winning a conflict. Which frame is chosen, how many cycles that takes, and whether the clean preference gives way after a full lap depend on the history of the bits. Only the bench's scenarios can show these, by comparing victims and latencies against a precomputed sequence. That sequence includes an access that collides with a sweep clear and a request issued during a sweep.

// File: rtl/clkrep_pkg.sv
package clkrep_pkg;
  typedef enum logic {
    SW_IDLE = 1'b0,
    SW_SCAN = 1'b1
  } sweep_state_e;
endpackage

// File: rtl/clkrep_frame_bits.sv
// Per-frame use and dirty bits. Access reports win over any clear.
module clkrep_frame_bits #(
  parameter int NFRAMES = 16,
  localparam int IDX_W  = $clog2(NFRAMES)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               acc_valid,
  input  logic [IDX_W-1:0]   acc_idx,
  input  logic               acc_write,
  input  logic               fill_valid,
  input  logic [IDX_W-1:0]   fill_idx,
  input  logic               clr_valid,
  input  logic [IDX_W-1:0]   clr_idx,
  output logic [NFRAMES-1:0] use_vec,
  output logic [NFRAMES-1:0] dirty_vec
);

  for (genvar g = 0; g < NFRAMES; g++) begin : g_frame
    logic hit_acc, hit_fill, hit_clr;
    logic use_en, use_d, dirty_en, dirty_d;

    always_comb begin
      hit_acc  = acc_valid  && (acc_idx  == IDX_W'(g));
      hit_fill = fill_valid && (fill_idx == IDX_W'(g));
      hit_clr  = clr_valid  && (clr_idx  == IDX_W'(g));
      use_en   = hit_acc || hit_fill || hit_clr;
      use_d    = hit_acc;
      dirty_en = (hit_acc && acc_write) || hit_fill;
      dirty_d  = hit_acc && acc_write;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        use_vec[g]   <= 1'b0;
        dirty_vec[g] <= 1'b0;
      end else begin
        if (use_en)   use_vec[g]   <= use_d;
        if (dirty_en) dirty_vec[g] <= dirty_d;
      end
    end
  end

endmodule

// File: rtl/clkrep_sweep.sv
// Hand pointer and sweep control: one frame examined per cycle.
module clkrep_sweep
  import clkrep_pkg::*;
#(
  parameter int NFRAMES = 16,
  localparam int IDX_W  = $clog2(NFRAMES)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req,
  input  logic [NFRAMES-1:0] use_vec,
  input  logic [NFRAMES-1:0] dirty_vec,
  output logic               busy,
  output logic               clr_valid,
  output logic [IDX_W-1:0]   clr_idx,
  output logic               pick_valid,
  output logic [IDX_W-1:0]   pick_idx,
  output logic               pick_dirty,
  output logic [IDX_W-1:0]   hand,
  output logic               lap
);

  localparam logic [IDX_W-1:0] LAST = IDX_W'(NFRAMES - 1);

  sweep_state_e     state_q, state_d;
  logic [IDX_W-1:0] hand_q, hand_d;
  logic [IDX_W-1:0] step_q, step_d;
  logic             lap_q, lap_d;
  logic             hand_en, step_en;
  logic             scanning, start, cur_use, cur_dirty, accept;

  always_comb begin
    scanning   = (state_q == SW_SCAN);
    start      = (state_q == SW_IDLE) && req;
    cur_use    = use_vec[hand_q];
    cur_dirty  = dirty_vec[hand_q];
    accept     = scanning && !cur_use && (lap_q || !cur_dirty);

    clr_valid  = scanning && cur_use;
    clr_idx    = hand_q;
    pick_valid = accept;
    pick_idx   = hand_q;
    pick_dirty = cur_dirty;

    state_d = state_q;
    if (start)  state_d = SW_SCAN;
    if (accept) state_d = SW_IDLE;

    hand_en = scanning;
    hand_d  = (hand_q == LAST) ? '0 : hand_q + 1'b1;

    step_en = start || (scanning && !accept && !lap_q);
    step_d  = start ? '0 : step_q + 1'b1;
    lap_d   = lap_q;
    if (start)
      lap_d = 1'b0;
    else if (scanning && !accept && !lap_q && (step_q == LAST))
      lap_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SW_IDLE;
      hand_q  <= '0;
      step_q  <= '0;
      lap_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      if (hand_en) hand_q <= hand_d;
      if (step_en) begin
        step_q <= step_d;
        lap_q  <= lap_d;
      end
    end
  end

  assign busy = scanning;
  assign hand = hand_q;
  assign lap  = lap_q;

endmodule

// File: rtl/clkrep_result.sv
// Registered victim report.
module clkrep_result #(
  parameter int NFRAMES = 16,
  localparam int IDX_W  = $clog2(NFRAMES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pick_valid,
  input  logic [IDX_W-1:0] pick_idx,
  input  logic             pick_dirty,
  output logic             done,
  output logic [IDX_W-1:0] victim_idx,
  output logic             victim_dirty
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done         <= 1'b0;
      victim_idx   <= '0;
      victim_dirty <= 1'b0;
    end else begin
      done <= pick_valid;
      if (pick_valid) begin
        victim_idx   <= pick_idx;
        victim_dirty <= pick_dirty;
      end
    end
  end

endmodule

// File: rtl/clock_victim_sel.sv
module clock_victim_sel #(
  parameter int NFRAMES = 16,
  localparam int IDX_W  = $clog2(NFRAMES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             acc_valid,
  input  logic [IDX_W-1:0] acc_idx,
  input  logic             acc_write,
  input  logic             fill_valid,
  input  logic [IDX_W-1:0] fill_idx,
  input  logic             req,
  output logic             busy,
  output logic             done,
  output logic [IDX_W-1:0] victim_idx,
  output logic             victim_dirty
);

  logic [NFRAMES-1:0] use_vec, dirty_vec;
  logic               clr_valid, pick_valid, pick_dirty, lap;
  logic [IDX_W-1:0]   clr_idx, pick_idx, hand;

  clkrep_frame_bits #(.NFRAMES(NFRAMES)) u_bits (
    .clk, .rst_n, .acc_valid, .acc_idx, .acc_write, .fill_valid, .fill_idx,
    .clr_valid, .clr_idx, .use_vec, .dirty_vec
  );

  clkrep_sweep #(.NFRAMES(NFRAMES)) u_sweep (
    .clk, .rst_n, .req, .use_vec, .dirty_vec, .busy, .clr_valid, .clr_idx,
    .pick_valid, .pick_idx, .pick_dirty, .hand, .lap
  );

  clkrep_result #(.NFRAMES(NFRAMES)) u_result (
    .clk, .rst_n, .pick_valid, .pick_idx, .pick_dirty,
    .done, .victim_idx, .victim_dirty
  );

endmodule

// File: rtl/clock_victim_sel_chk.sv
module clock_victim_sel_chk #(
  parameter int NFRAMES = 16,
  localparam int IDX_W  = $clog2(NFRAMES)
) (
  input logic               clk,
  input logic               rst_n,
  input logic               acc_valid,
  input logic [IDX_W-1:0]   acc_idx,
  input logic               acc_write,
  input logic               fill_valid,
  input logic [IDX_W-1:0]   fill_idx,
  input logic               busy,
  input logic               done,
  input logic               victim_dirty,
  input logic [IDX_W-1:0]   hand,
  input logic               lap,
  input logic [NFRAMES-1:0] use_vec,
  input logic [NFRAMES-1:0] dirty_vec
);

  function automatic logic [IDX_W-1:0] nxt(input logic [IDX_W-1:0] h);
    return (h == IDX_W'(NFRAMES - 1)) ? '0 : h + 1'b1;
  endfunction

  assert_access_sets_use_R2: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid |=> use_vec[$past(acc_idx)]);

  assert_write_sets_dirty_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && acc_write) |=> dirty_vec[$past(acc_idx)]);

  assert_fill_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_valid && !(acc_valid && acc_idx == fill_idx))
      |=> (!use_vec[$past(fill_idx)] && !dirty_vec[$past(fill_idx)]));

  assert_hand_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> (hand == nxt($past(hand))));

  assert_hand_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |=> $stable(hand));

  assert_first_lap_clean_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !lap) |-> !victim_dirty);

  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_not_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

endmodule

bind clock_victim_sel clock_victim_sel_chk #(.NFRAMES(NFRAMES)) u_chk (
  .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_idx(acc_idx),
  .acc_write(acc_write), .fill_valid(fill_valid), .fill_idx(fill_idx),
  .busy(busy), .done(done), .victim_dirty(victim_dirty), .hand(hand),
  .lap(lap), .use_vec(use_vec), .dirty_vec(dirty_vec)
);

// File: tb/clock_victim_sel_test.sv
`timescale 1ns/1ps
module clock_victim_sel_test;
  localparam int NFRAMES = 16;
  localparam int IDX_W   = $clog2(NFRAMES);

  logic             clk = 1'b0;
  logic             rst_n;
  logic             acc_valid, acc_write, fill_valid, req;
  logic [IDX_W-1:0] acc_idx, fill_idx;
  logic             busy, done, victim_dirty;
  logic [IDX_W-1:0] victim_idx;

  always #2 clk = ~clk;

  clock_victim_sel #(.NFRAMES(NFRAMES)) uut (
    .clk, .rst_n, .acc_valid, .acc_idx, .acc_write, .fill_valid, .fill_idx,
    .req, .busy, .done, .victim_idx, .victim_dirty
  );

  typedef struct {
    int    idx;
    bit    dirty;
    int    exams;
    string tag;
  } exp_t;

  exp_t exp_q[$];
  int   checks = 0, failures = 0;
  int   cyc = 0, t0 = 0;
  bit   done_seen = 0, prev_done = 0, finished = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string tag, input int act, input int expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  // Monitor: pops expected victims as done pulses appear.
  always @(negedge clk) begin
    if (rst_n) begin
      if (done && prev_done) check(0, "R10 done longer than one cycle", 1, 0);
      if (done) begin
        if (exp_q.size() == 0) begin
          check(0, "R10 unexpected done", 1, 0);
        end else begin
          exp_t e;
          e = exp_q.pop_front();
          check(int'(victim_idx) == e.idx, {e.tag, " victim_idx"}, int'(victim_idx), e.idx);
          check(victim_dirty == e.dirty, {e.tag, " victim_dirty"}, int'(victim_dirty), int'(e.dirty));
          check(cyc - t0 == e.exams, {e.tag, " latency"}, cyc - t0, e.exams);
          check(!busy, {e.tag, " busy low at done"}, int'(busy), 0);
        end
        done_seen = 1;
      end
      prev_done = done;
    end
  end

  task automatic access(input int idx, input bit wr);
    @(negedge clk);
    acc_valid = 1; acc_idx = IDX_W'(idx); acc_write = wr;
    @(negedge clk);
    acc_valid = 0; acc_write = 0;
  endtask

  task automatic reload(input int idx);
    @(negedge clk);
    fill_valid = 1; fill_idx = IDX_W'(idx);
    @(negedge clk);
    fill_valid = 0;
  endtask

  task automatic write_and_reload(input int idx);
    @(negedge clk);
    acc_valid = 1; acc_idx = IDX_W'(idx); acc_write = 1;
    fill_valid = 1; fill_idx = IDX_W'(idx);
    @(negedge clk);
    acc_valid = 0; acc_write = 0; fill_valid = 0;
  endtask

  // Driver: pushes the expected victim, then issues the request.
  task automatic request(input int idx, input bit dirty, input int exams, input string tag,
                         input int collide_idx, input bit extra_req);
    exp_q.push_back('{idx, dirty, exams, tag});
    done_seen = 0;
    @(negedge clk);
    req = 1; t0 = cyc + 1;
    @(negedge clk);
    req = 0;
    if (collide_idx >= 0) begin
      acc_valid = 1; acc_idx = IDX_W'(collide_idx); acc_write = 0;
    end
    @(negedge clk);
    acc_valid = 0;
    if (extra_req) begin
      check(busy == 1'b1, "R10 busy during sweep", int'(busy), 1);
      req = 1;
      @(negedge clk);
      req = 0;
    end
    while (!done_seen) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    rst_n = 0; acc_valid = 0; acc_write = 0; acc_idx = '0;
    fill_valid = 0; fill_idx = '0; req = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    check(done == 0, "R1 done after reset", int'(done), 0);
    check(busy == 0, "R1 busy after reset", int'(busy), 0);
    check(victim_dirty == 0, "R1 victim_dirty after reset", int'(victim_dirty), 0);
    check(victim_idx == 0, "R1 victim_idx after reset", int'(victim_idx), 0);

    // R1: all bits clear, hand at 0
    request(0, 0, 1, "R1 first request", -1, 0);

    // R2/R3: used frames 1..3 cleared on the way, frame 4 chosen
    access(1, 0); access(2, 0); access(3, 1);
    request(4, 0, 4, "R3 sweep past used frames", -1, 0);

    // R7: hand sits after the last victim
    request(5, 0, 1, "R7 hand after victim", -1, 0);

    // R5/R6: everything used and dirty, hand at 6
    for (int i = 0; i < NFRAMES; i++) access(i, 1);
    request(6, 1, NFRAMES + 1, "R6 all used and dirty", -1, 0);

    // R4/R8: reload 9 makes it the only clean frame
    reload(9);
    request(9, 0, 3, "R4 skip unused dirty", -1, 0);

    // R8: a written frame that is reloaded becomes a clean candidate
    access(10, 1); reload(10);
    request(10, 0, 1, "R8 reload clears bits", -1, 0);

    // R9: write and reload in the same cycle, the write wins
    write_and_reload(11); reload(12);
    request(12, 0, 2, "R9 access beats reload", -1, 0);

    // R9: access collides with the sweep clear of frame 13
    access(9, 1); access(10, 1); access(12, 1); access(13, 0);
    request(14, 1, NFRAMES + 2, "R9 access beats sweep clear", 13, 0);

    // R10: a request during a sweep is ignored
    request(15, 1, NFRAMES + 1, "R10 request while busy", -1, 1);
    repeat (NFRAMES + 8) @(negedge clk);
    check(exp_q.size() == 0, "R10 pending expectations", exp_q.size(), 0);

    // R7: hand wrapped from the last frame to 0
    reload(0);
    request(0, 0, 1, "R7 hand wraps", -1, 0);

    repeat (4) @(negedge clk);
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule